// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one serial flash command at a time. Software loads a 24-bit address register and a 32-bit data register, then writes a command word. The sequencer selects the device and shifts the command out one bit at a time, most significant bit first. The phases are an 8-bit opcode, up to three address bytes, up to fifteen all-zero dummy bytes, and up to four data bytes. The data bytes are either sent from the data register or captured into it. While the command runs, a pending flag in the status word stays high. A command word that arrives while another command is still running is dropped, and an error flag is raised instead.

The bit rate is set outside the block. A launch strobe moves the next bit onto the data-out line and drives the serial clock low. A sample strobe captures data-in and drives the serial clock high again. A keep-selected bit in the command word leaves chip select asserted after the command ends. Software can therefore split one long flash transaction into several commands of four data bytes or fewer. Later commands in such a chain skip the opcode, and usually carry zero address and dummy lengths. A command with no data and keep-selected clear deselects the device. A 4-bit register sets the levels driven on the data lines that single-line transfers leave unused.

Top module: `sflash_cmd_seq`

## Requirements
- R1: A command write while no command is pending sets the pending flag (status bit 22) on the next cycle. The flag clears by itself once every phase has been shifted.
- R2: Command word fields are: opcode [7:0], write direction bit 8, data length [11:9], keep-selected bit 15, dummy length [19:16], address length [22:20], chip-select index [26:24]. Bits go out in this order: opcode, then address, then dummy bytes, then data. Every byte is sent most significant bit first. The address phase sends the low `n` bytes of the address register with the most significant of those first, where `n` is the address length; values above 3 count as 3. Each dummy byte is zero. The opcode is skipped when chip select is still held from a previous keep-selected command.
- R3: A write command (bit 8 set) sends its data bytes starting with bits [7:0] of the data register, then each higher byte in turn. A data length above 4 counts as 4.
- R4: A read command (bit 8 clear) first clears the data register. It then stores each captured byte at successively higher byte positions, starting at bits [7:0], and drives data-out low during its data phase.
- R5: When the command has keep-selected set, chip select stays asserted after the command ends. When keep-selected is clear, chip select is released when the command ends.
- R6: A command with zero address, dummy and data lengths, keep-selected clear, and chip select already held shifts no bits. It only deselects the device.
- R7: A command write while pending sets the error flag (status bit 29) and has no effect on the command that is running.
- R8: Writing the status word with bit 29 set clears the error flag, and writing it with bit 29 clear leaves the flag unchanged. If a clear and a new error arrive in the same cycle, the error wins.
- R9: The unused-line levels reset to 4'b1100 and follow writes to the I/O level register.
- R10: Data-out changes only on a launch strobe. The serial clock is low from a launch to the next sample and is high whenever no command is pending. Strobes that arrive out of turn, or while idle, are ignored.
- R11: Active-low chip select asserts exactly the line named by the index field while the device is selected, and no line otherwise.
- R12: Writes to the address and data registers while a command is pending are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word |
| addr_wr | input | 1 | Address register write strobe |
| addr_wdata | input | 24 | Address value |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 32 | Data value |
| stat_wr | input | 1 | Status write strobe (bit 29 clears error) |
| stat_wdata | input | 32 | Status write value |
| io_wr | input | 1 | I/O level register write strobe |
| io_wdata | input | 4 | Unused-line levels |
| bit_launch | input | 1 | Launch strobe: next bit out, serial clock low |
| bit_sample | input | 1 | Sample strobe: capture data-in, serial clock high |
| sdi | input | 1 | Serial data in |
| data_rdata | output | 32 | Data register contents |
| status | output | 32 | Status: bit 22 pending, bit 29 error |
| cs_n | output | NUM_CS | Active-low chip selects |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| io_lvl | output | 4 | Levels for unused data lines |

## Verification
Two status updates can land on the same clock edge. A software write that clears the error flag can coincide with a command write that collides with a running command. The bench provokes this by issuing both writes in the cycle after a command starts. It expects the error flag to read as set afterwards, because the new error takes priority over the clear. It also expects the command that was already running to shift out exactly the bit stream predicted from its own fields.

// File: rtl/sflash_cmd_seq.sv
module sflash_cmd_seq #(
  parameter int NUM_CS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [31:0]       cmd_wdata,
  input  logic              addr_wr,
  input  logic [23:0]       addr_wdata,
  input  logic              data_wr,
  input  logic [31:0]       data_wdata,
  input  logic              stat_wr,
  input  logic [31:0]       stat_wdata,
  input  logic              io_wr,
  input  logic [3:0]        io_wdata,
  input  logic              bit_launch,
  input  logic              bit_sample,
  input  logic              sdi,
  output logic [31:0]       data_rdata,
  output logic [31:0]       status,
  output logic [NUM_CS-1:0] cs_n,
  output logic              sck,
  output logic              sdo,
  output logic [3:0]        io_lvl
);

  localparam int PEND_BIT = 22;
  localparam int ERR_BIT  = 29;
  localparam int MAX_ABYTES = 3;
  localparam int MAX_DBYTES = 4;

  typedef enum logic [2:0] {PH_IDLE, PH_OPC, PH_ADR, PH_DUM, PH_DAT, PH_END} ph_t;

  ph_t         ph_q;
  logic [2:0]  bit_q;
  logic [3:0]  byte_q;
  logic [7:0]  opc_q;
  logic [1:0]  alen_q;
  logic [3:0]  dum_q;
  logic [2:0]  dlen_q;
  logic        wr_q, keep_q, sel_q, err_q, sck_q, sdo_q;
  logic [2:0]  csi_q;
  logic [23:0] addr_q;
  logic [31:0] data_q;
  logic [3:0]  io_q;

  logic        busy, shifting, tx_bit;
  logic [1:0]  c_al, aidx;
  logic [2:0]  c_dl;
  logic [3:0]  c_du, nbytes;
  logic [4:0]  dpos;
  ph_t         c_first;

  function automatic ph_t after(ph_t p, logic [1:0] al, logic [3:0] du, logic [2:0] dl);
    ph_t r;
    r = PH_END;
    if (p < PH_DAT && dl != 3'd0) r = PH_DAT;
    if (p < PH_DUM && du != 4'd0) r = PH_DUM;
    if (p < PH_ADR && al != 2'd0) r = PH_ADR;
    return r;
  endfunction

  assign busy     = (ph_q != PH_IDLE);
  assign shifting = (ph_q == PH_OPC) || (ph_q == PH_ADR) || (ph_q == PH_DUM) || (ph_q == PH_DAT);

  assign c_al    = (cmd_wdata[22:20] > 3'(MAX_ABYTES)) ? 2'(MAX_ABYTES) : cmd_wdata[21:20];
  assign c_dl    = (cmd_wdata[11:9] > 3'(MAX_DBYTES)) ? 3'(MAX_DBYTES) : cmd_wdata[11:9];
  assign c_du    = cmd_wdata[19:16];
  assign c_first = sel_q ? after(PH_OPC, c_al, c_du, c_dl) : PH_OPC;

  assign aidx = alen_q - 2'd1 - byte_q[1:0];
  assign dpos = {byte_q[1:0], ~bit_q};

  always_comb begin
    case (ph_q)
      PH_OPC:  tx_bit = opc_q[~bit_q];
      PH_ADR:  tx_bit = addr_q[{aidx, ~bit_q}];
      PH_DAT:  tx_bit = wr_q & data_q[dpos];
      default: tx_bit = 1'b0;
    endcase
  end

  always_comb begin
    case (ph_q)
      PH_ADR:  nbytes = {2'b00, alen_q};
      PH_DUM:  nbytes = dum_q;
      PH_DAT:  nbytes = {1'b0, dlen_q};
      default: nbytes = 4'd1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      bit_q  <= '0;
      byte_q <= '0;
      opc_q  <= '0;
      alen_q <= '0;
      dum_q  <= '0;
      dlen_q <= '0;
      wr_q   <= 1'b0;
      keep_q <= 1'b0;
      sel_q  <= 1'b0;
      err_q  <= 1'b0;
      sck_q  <= 1'b1;
      sdo_q  <= 1'b0;
      csi_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      io_q   <= 4'b1100;
    end else begin
      if (io_wr) io_q <= io_wdata;
      if (addr_wr && !busy) addr_q <= addr_wdata;
      if (data_wr && !busy) data_q <= data_wdata;
      if (stat_wr && stat_wdata[ERR_BIT]) err_q <= 1'b0;

      if (cmd_wr) begin
        if (busy) begin
          err_q <= 1'b1;
        end else begin
          opc_q  <= cmd_wdata[7:0];
          wr_q   <= cmd_wdata[8];
          dlen_q <= c_dl;
          keep_q <= cmd_wdata[15];
          dum_q  <= c_du;
          alen_q <= c_al;
          csi_q  <= cmd_wdata[26:24];
          sel_q  <= 1'b1;
          bit_q  <= '0;
          byte_q <= '0;
          ph_q   <= c_first;
          if (!cmd_wdata[8]) data_q <= '0;
        end
      end

      if (shifting && bit_launch && sck_q) begin
        sdo_q <= tx_bit;
        sck_q <= 1'b0;
      end

      if (shifting && bit_sample && !sck_q) begin
        sck_q <= 1'b1;
        if (ph_q == PH_DAT && !wr_q) data_q[dpos] <= sdi;
        if (bit_q == 3'd7) begin
          bit_q <= '0;
          if (byte_q == nbytes - 4'd1) begin
            byte_q <= '0;
            ph_q   <= after(ph_q, alen_q, dum_q, dlen_q);
          end else begin
            byte_q <= byte_q + 4'd1;
          end
        end else begin
          bit_q <= bit_q + 3'd1;
        end
      end

      if (ph_q == PH_END) begin
        ph_q  <= PH_IDLE;
        sel_q <= keep_q;
      end
    end
  end

  logic [7:0] cs_dec;
  assign cs_dec = 8'b1 << csi_q;

  assign cs_n       = sel_q ? ~cs_dec[NUM_CS-1:0] : '1;
  assign sck        = sck_q;
  assign sdo        = sdo_q;
  assign io_lvl     = io_q;
  assign data_rdata = data_q;

  always_comb begin
    status           = '0;
    status[PEND_BIT] = busy;
    status[ERR_BIT]  = err_q;
  end

endmodule

// File: rtl/sflash_cmd_seq_chk.sv
module sflash_cmd_seq_chk #(
  parameter int NUM_CS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_wr,
  input logic              clr_req,
  input logic              bit_launch,
  input logic [31:0]       status,
  input logic [NUM_CS-1:0] cs_n,
  input logic              sck,
  input logic              sdo,
  input logic              keep
);

  assert_cmd_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !status[22] |=> status[22]);

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[22]) && !keep |-> (&cs_n));

  assert_collision_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && status[22] |=> status[29]);

  assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !(cmd_wr && status[22]) |=> !status[29]);

  assert_sdo_launch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_launch |=> $stable(sdo));

  assert_sck_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !status[22] |-> sck);

  assert_cs_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

endmodule

bind sflash_cmd_seq sflash_cmd_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr),
  .clr_req(stat_wr && stat_wdata[29]), .bit_launch(bit_launch),
  .status(status), .cs_n(cs_n), .sck(sck), .sdo(sdo), .keep(keep_q)
);

// File: tb/sflash_cmd_seq_test.sv
module sflash_cmd_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 0, addr_wr = 0, data_wr = 0, stat_wr = 0, io_wr = 0;
  logic [31:0] cmd_wdata = 0, data_wdata = 0, stat_wdata = 0;
  logic [23:0] addr_wdata = 0;
  logic [3:0]  io_wdata = 0;
  logic bit_launch = 0, bit_sample = 0, sdi = 0;
  logic [31:0] data_rdata, status;
  logic [7:0]  cs_n;
  logic sck, sdo;
  logic [3:0] io_lvl;

  sflash_cmd_seq #(.NUM_CS(8)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .addr_wr(addr_wr), .addr_wdata(addr_wdata), .data_wr(data_wr), .data_wdata(data_wdata),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .io_wr(io_wr), .io_wdata(io_wdata),
    .bit_launch(bit_launch), .bit_sample(bit_sample), .sdi(sdi),
    .data_rdata(data_rdata), .status(status), .cs_n(cs_n), .sck(sck), .sdo(sdo), .io_lvl(io_lvl));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit exp_bits [0:255];
  bit got_bits [0:255];
  int nexp, ngot, hdr_len;
  logic [7:0] exp_cs;
  bit cs_bad;
  bit m_sel = 0;
  logic [23:0] m_addr = 0;
  logic [31:0] m_data = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push8(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      exp_bits[nexp] = v[i];
      nexp++;
    end
  endtask

  task automatic write_addr(input logic [23:0] a);
    @(negedge clk); addr_wr = 1; addr_wdata = a;
    @(negedge clk); addr_wr = 0;
    m_addr = a;
  endtask

  task automatic write_data(input logic [31:0] d);
    @(negedge clk); data_wr = 1; data_wdata = d;
    @(negedge clk); data_wr = 0;
    m_data = d;
  endtask

  task automatic write_stat(input logic [31:0] v);
    @(negedge clk); stat_wr = 1; stat_wdata = v;
    @(negedge clk); stat_wr = 0;
  endtask

  task automatic shift_all(input logic [31:0] rd_src);
    ngot = 0;
    cs_bad = 0;
    for (int it = 0; it < 800 && status[22]; it++) begin
      bit_sample = 1;
      @(negedge clk);
      bit_sample = 0;
      bit_launch = 1;
      if (ngot >= hdr_len) begin
        int j;
        j = ngot - hdr_len;
        sdi = rd_src[(j / 8) * 8 + 7 - (j % 8)];
      end else begin
        sdi = 1'b1;
      end
      @(negedge clk);
      bit_launch = 0;
      if (!sck) begin
        got_bits[ngot] = sdo;
        if (cs_n !== exp_cs) cs_bad = 1;
        ngot++;
      end
      bit_sample = 1;
      @(negedge clk);
      bit_sample = 0;
      @(negedge clk);
    end
  endtask

  // mode: 0 none, 1 collision plus register writes, 2 collision plus error clear
  task automatic do_cmd(input logic [31:0] cmd, input logic [31:0] rd_src, input int mode);
    logic [1:0] al; logic [3:0] du; logic [2:0] dl; logic wr, keep; logic [2:0] csi;
    logic [63:0] mask;
    int mism_h, mism_d;
    al   = (cmd[22:20] > 3) ? 2'd3 : cmd[21:20];
    dl   = (cmd[11:9] > 4) ? 3'd4 : cmd[11:9];
    du   = cmd[19:16];
    wr   = cmd[8];
    keep = cmd[15];
    csi  = cmd[26:24];
    nexp = 0;
    if (!m_sel) push8(cmd[7:0]);
    for (int k = 0; k < 3; k++) if (k < al) push8(8'(m_addr >> (8 * (al - 1 - k))));
    for (int k = 0; k < 16; k++) if (k < du) push8(8'h00);
    hdr_len = nexp;
    for (int k = 0; k < 4; k++) if (k < dl) push8(wr ? m_data[8*k +: 8] : 8'h00);
    exp_cs = ~(8'b1 << csi);

    @(negedge clk); cmd_wr = 1; cmd_wdata = cmd;
    @(negedge clk); cmd_wr = 0;
    check(status[22] === 1'b1, "R1 pending after command", 64'(status[22]), 1);

    if (mode != 0) begin
      cmd_wr = 1; cmd_wdata = ~cmd;
      if (mode == 1) begin
        addr_wr = 1; addr_wdata = ~m_addr;
        data_wr = 1; data_wdata = ~m_data;
      end else begin
        stat_wr = 1; stat_wdata = 32'h2000_0000;
      end
      @(negedge clk);
      cmd_wr = 0; addr_wr = 0; data_wr = 0; stat_wr = 0;
      if (mode == 1) check(status[29] === 1'b1, "R7 error on collision", 64'(status[29]), 1);
      else check(status[29] === 1'b1, "R8 error wins over clear", 64'(status[29]), 1);
    end

    shift_all(rd_src);
    check(ngot == nexp, "R2 bit count", 64'(ngot), 64'(nexp));
    mism_h = 0; mism_d = 0;
    for (int i = 0; i < 256; i++) begin
      if (i < ngot && i < nexp && got_bits[i] !== exp_bits[i]) begin
        if (i < hdr_len) mism_h++; else mism_d++;
      end
    end
    check(mism_h == 0, "R2 opcode/address/dummy bits", 64'(mism_h), 0);
    check(mism_d == 0, wr ? "R3 write data bits" : "R4 read phase sdo low", 64'(mism_d), 0);
    if (nexp > 0) check(!cs_bad, "R11 chip select during command", 64'(cs_bad), 0);
    check(status[22] === 1'b0, "R1 pending cleared", 64'(status[22]), 0);
    m_sel = keep;
    check(cs_n === (keep ? exp_cs : 8'hFF), "R5 chip select after command", 64'(cs_n), 64'(keep ? exp_cs : 8'hFF));
    check(sck === 1'b1, "R10 sck idle high", 64'(sck), 1);
    if (!wr) begin
      mask = (dl == 0) ? 64'h0 : ((64'h1 << (8 * dl)) - 64'h1);
      m_data = rd_src & mask[31:0];
      check(data_rdata === m_data, "R4 read data", 64'(data_rdata), 64'(m_data));
    end else begin
      check(data_rdata === m_data, "R3 R12 data register kept", 64'(data_rdata), 64'(m_data));
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] opc, input bit wr, input int dl,
                                     input bit keep, input int du, input int al, input int csi);
    return {5'b0, 3'(csi), 1'b0, 3'(al), 4'(du), keep, 3'b0, 3'(dl), wr, opc};
  endfunction

  bit wd_fired = 0;
  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    wd_fired = 1;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic sdo_before;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(status === 32'h0, "R1 reset status", 64'(status), 0);
    check(cs_n === 8'hFF, "R11 reset chip select", 64'(cs_n), 64'hFF);
    check(sck === 1'b1, "R10 reset sck", 64'(sck), 1);
    check(io_lvl === 4'b1100, "R9 reset io levels", 64'(io_lvl), 64'hC);
    check(data_rdata === 32'h0, "R4 reset data", 64'(data_rdata), 0);

    @(negedge clk); io_wr = 1; io_wdata = 4'b0101;
    @(negedge clk); io_wr = 0;
    check(io_lvl === 4'b0101, "R9 io level write", 64'(io_lvl), 64'h5);
    @(negedge clk); io_wr = 1; io_wdata = 4'b1100;
    @(negedge clk); io_wr = 0;

    sdo_before = sdo;
    @(negedge clk); bit_launch = 1;
    @(negedge clk); bit_launch = 0; bit_sample = 1;
    @(negedge clk); bit_sample = 0;
    check(sdo === sdo_before && sck === 1'b1, "R10 idle strobes ignored", 64'({sck, sdo}), 64'({1'b1, sdo_before}));

    write_addr(24'hA1B2C3);
    write_data(32'h8041_22F0);
    do_cmd(mk(8'h02, 1, 4, 0, 0, 3, 0), 32'h0, 0);

    write_addr(24'h123456);
    do_cmd(mk(8'h0B, 0, 4, 1, 1, 3, 2), 32'hDEAD_BEEF, 0);
    do_cmd(mk(8'h0B, 0, 4, 1, 0, 0, 2), 32'h0102_0304, 0);
    do_cmd(mk(8'h0B, 0, 2, 0, 0, 0, 2), 32'hFFFF_A55A, 0);

    write_data(32'h0000_00C3);
    do_cmd(mk(8'h06, 1, 1, 1, 0, 0, 5), 32'h0, 0);
    do_cmd(mk(8'h00, 0, 0, 0, 0, 0, 5), 32'h0, 0);
    check(nexp == 0 && ngot == 0, "R6 deselect shifts nothing", 64'(ngot), 0);

    write_addr(24'h00FF01);
    write_data(32'h1357_9BDF);
    do_cmd(mk(8'h32, 1, 7, 0, 2, 2, 1), 32'h0, 1);
    write_stat(32'h0);
    check(status[29] === 1'b1, "R8 no clear without bit 29", 64'(status[29]), 1);
    write_stat(32'h2000_0000);
    check(status[29] === 1'b0, "R8 clear by bit 29", 64'(status[29]), 0);

    do_cmd(mk(8'hA5, 0, 3, 0, 0, 1, 7), 32'h00C0_FFEE, 2);
    write_stat(32'h2000_0000);
    check(status[29] === 1'b0, "R8 clear after set-wins", 64'(status[29]), 0);

    for (int n = 0; n < 40; n++) begin
      logic [31:0] cmd;
      write_addr(24'($urandom));
      write_data($urandom);
      cmd = mk(8'($urandom), 1'($urandom), int'($urandom % 8), 1'($urandom),
               ($urandom % 4 == 0) ? int'($urandom % 16) : int'($urandom % 3),
               int'($urandom % 8), int'($urandom % 8));
      do_cmd(cmd, $urandom, 0);
    end

    if (m_sel) do_cmd(mk(8'h00, 0, 0, 0, 0, 0, 0), 32'h0, 0);

    if (!wd_fired) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule